// File: doc/BRIEF.md
# Multi-Input Wake-Up Event Controller

The controller watches several groups of eight asynchronous wake-up lines. Each line has its own settings: level or edge sensing, polarity, and an override that senses both edges. An enabled line that sees its condition sets a sticky pending bit in its group. Each pending bit is gated by an interrupt-enable bit. The gated bits of a chosen set of groups are merged onto each of a small number of shared interrupt outputs. The set of groups for each output is fixed by a mask parameter.

Software reaches the controller through a flat register port with a one-cycle write strobe and a combinational read. Each group has six registers: mode, polarity, any-edge, input-enable, interrupt-enable and pending. Pending is read-only. A separate write-only clear register clears pending bits, one per bit written as 1. Software must clear pending after it changes an input-enable bit, because that change can raise a spurious event. Every line passes through a two-flop synchroniser before detection.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset every register reads 0 and every irq_o bit is 0.
- R2: The register address is {group, field}, with field in bits [2:0]. The field codes are: 0 mode, 1 polarity, 2 any-edge, 3 input-enable, 4 interrupt-enable, 5 pending, 6 clear. Fields 0 to 4 read back the last value written. Fields 6 and 7 read as 0.
- R3: With mode bit 1 the line is level sensed. Polarity 0 detects high and polarity 1 detects low. A pending bit cleared while its level is still present sets again one cycle later.
- R4: With mode bit 0 and any-edge 0, polarity 0 detects a rising edge and polarity 1 detects a falling edge. An edge is a change between two consecutive synchronised samples.
- R5: With mode bit 0 and any-edge 1, both edges are detected whatever the polarity bit holds.
- R6: A line whose input-enable bit is 0 never sets its pending bit.
- R7: Pending bits latch whether or not interrupt-enable is set. A group's request is pending AND interrupt-enable, bit by bit.
- R8: Writing the clear field clears every pending bit written as 1 and leaves the bits written as 0. If a detection and a clear hit the same bit in the same cycle, the bit stays set.
- R9: irq_o[k] is the OR of the requests of every group g whose bit k*N_GROUPS+g is set in IRQ_MASK. The default mask is 8'h69: irq_o[0] merges groups 0 and 3, and irq_o[1] merges groups 1 and 2.
- R10: A change on wake_i sets pending on the third rising clock edge after the change. irq_o follows pending in the same cycle.
- R11: A write to the pending field (code 5) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_i | input | N_GROUPS*8 | Asynchronous wake-up lines, group g in bits [g*8+7:g*8] |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | GRP_AW+3 | Register address {group, field} |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| irq_o | output | N_IRQ | Merged interrupt requests |

## Verification
The assertions assume that the register port is sampled only at the rising clock edge. They also assume that a clear arrives only as a write to field 6 of a single group in the cycle the strobe is high. The wake lines are free to change at any time, because every assertion looks only at the synchronised samples. The bench changes the wake lines, the strobe, the address and the data on the falling edge, so every rising edge sees stable values. It keeps the address inside the populated groups.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned GRP_BITS = 8;
  localparam int unsigned FLD_BITS = 3;

  typedef enum logic [FLD_BITS-1:0] {
    FLD_MODE = 3'd0,
    FLD_POL  = 3'd1,
    FLD_ANY  = 3'd2,
    FLD_INEN = 3'd3,
    FLD_IEN  = 3'd4,
    FLD_PEND = 3'd5,
    FLD_CLR  = 3'd6,
    FLD_RSVD = 3'd7
  } fld_e;

  typedef struct packed {
    logic [GRP_BITS-1:0] mode;
    logic [GRP_BITS-1:0] pol;
    logic [GRP_BITS-1:0] any;
    logic [GRP_BITS-1:0] inen;
    logic [GRP_BITS-1:0] ien;
  } grp_cfg_t;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wkup_group.sv
module wkup_group
  import wkup_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [GRP_BITS-1:0] smp_i,
  input  logic                wr_en_i,
  input  fld_e                fld_i,
  input  logic [GRP_BITS-1:0] wdata_i,
  output logic [GRP_BITS-1:0] rdata_o,
  output logic [GRP_BITS-1:0] req_o
);
  grp_cfg_t            cfg_q;
  logic [GRP_BITS-1:0] prev_q, pend_q, hit, det, clr_v;

  for (genvar b = 0; b < GRP_BITS; b++) begin : g_bit
    assign hit[b] = cfg_q.mode[b] ? (smp_i[b] ^ cfg_q.pol[b]) :
                    cfg_q.any[b]  ? (smp_i[b] ^ prev_q[b]) :
                    cfg_q.pol[b]  ? (prev_q[b] & ~smp_i[b]) :
                                    (smp_i[b] & ~prev_q[b]);
  end

  assign det   = hit & cfg_q.inen;
  assign clr_v = (wr_en_i && fld_i == FLD_CLR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= smp_i;
      // detection overrides a clear of the same bit
      pend_q <= (pend_q & ~clr_v) | det;
      if (wr_en_i) begin
        case (fld_i)
          FLD_MODE: cfg_q.mode <= wdata_i;
          FLD_POL:  cfg_q.pol  <= wdata_i;
          FLD_ANY:  cfg_q.any  <= wdata_i;
          FLD_INEN: cfg_q.inen <= wdata_i;
          FLD_IEN:  cfg_q.ien  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (fld_i)
      FLD_MODE: rdata_o = cfg_q.mode;
      FLD_POL:  rdata_o = cfg_q.pol;
      FLD_ANY:  rdata_o = cfg_q.any;
      FLD_INEN: rdata_o = cfg_q.inen;
      FLD_IEN:  rdata_o = cfg_q.ien;
      FLD_PEND: rdata_o = pend_q;
      default:  rdata_o = '0;
    endcase
  end

  assign req_o = pend_q & cfg_q.ien;

  a_r6_set_needs_inen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(cfg_q.inen)) == '0));

  a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_v) & ~$past(det)) == '0));

  a_r7_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr_v)) == '0));

  a_r4_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(cfg_q.mode)
               & ~($past(smp_i) ^ $past(prev_q))) == '0));
endmodule

// File: rtl/wkup_irq_merge.sv
module wkup_irq_merge #(
  parameter int unsigned                      N_GROUPS = 4,
  parameter int unsigned                      N_IRQ    = 2,
  parameter logic [N_IRQ*N_GROUPS-1:0]        IRQ_MASK = 8'h69
) (
  input  logic [N_GROUPS-1:0] grp_req_i,
  output logic [N_IRQ-1:0]    irq_o
);
  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    assign irq_o[k] = |(grp_req_i & IRQ_MASK[k*N_GROUPS +: N_GROUPS]);
  end
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
  import wkup_pkg::*;
#(
  parameter int unsigned               N_GROUPS = 4,
  parameter int unsigned               N_IRQ    = 2,
  parameter logic [N_IRQ*N_GROUPS-1:0] IRQ_MASK = 8'h69,
  localparam int unsigned              GRP_AW   = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
  localparam int unsigned              ADDR_W   = GRP_AW + FLD_BITS,
  localparam int unsigned              IN_W     = N_GROUPS * GRP_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IN_W-1:0]     wake_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [GRP_BITS-1:0] reg_wdata_i,
  output logic [GRP_BITS-1:0] reg_rdata_o,
  output logic [N_IRQ-1:0]    irq_o
);
  logic [IN_W-1:0]     smp;
  logic [GRP_AW-1:0]   grp_sel;
  fld_e                fld;
  logic [GRP_BITS-1:0] grp_rd  [N_GROUPS];
  logic [N_GROUPS-1:0] grp_req;

  assign grp_sel = reg_addr_i[ADDR_W-1:FLD_BITS];
  assign fld     = fld_e'(reg_addr_i[FLD_BITS-1:0]);

  wkup_sync #(.W(IN_W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wake_i),
    .q_o   (smp)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [GRP_BITS-1:0] req;

    wkup_group i_group (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp[g*GRP_BITS +: GRP_BITS]),
      .wr_en_i(reg_we_i && (int'(grp_sel) == g)),
      .fld_i  (fld),
      .wdata_i(reg_wdata_i),
      .rdata_o(grp_rd[g]),
      .req_o  (req)
    );

    assign grp_req[g] = |req;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (int'(grp_sel) < N_GROUPS) reg_rdata_o = grp_rd[grp_sel];
  end

  wkup_irq_merge #(
    .N_GROUPS(N_GROUPS),
    .N_IRQ   (N_IRQ),
    .IRQ_MASK(IRQ_MASK)
  ) i_merge (
    .grp_req_i(grp_req),
    .irq_o    (irq_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/test_wkup_ctrl.sv
`timescale 1ns/1ps
module test_wkup_ctrl;
  localparam int NG = 4;
  localparam int NI = 2;
  localparam logic [7:0] MASK = 8'h69;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wake = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference state
  bit [7:0]  m_mode[NG], m_pol[NG], m_any[NG], m_inen[NG], m_ien[NG], m_pnd[NG];
  bit [31:0] m_s1, m_s2, m_prev;

  always #2.5 clk_i = ~clk_i;

  wkup_ctrl i_wkup_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wake_i(wake), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic m_reset();
    for (int g = 0; g < NG; g++) begin
      m_mode[g] = 0; m_pol[g] = 0; m_any[g] = 0;
      m_inen[g] = 0; m_ien[g] = 0; m_pnd[g] = 0;
    end
    m_s1 = 0; m_s2 = 0; m_prev = 0;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      for (int g = 0; g < NG; g++) begin
        bit [7:0] det, clr;
        bit wsel;
        wsel = we && (addr[4:3] == g[1:0]);
        clr = (wsel && addr[2:0] == 3'd6) ? wdata : 8'h00;
        for (int b = 0; b < 8; b++) begin
          bit s, p, h;
          s = m_s2[g*8+b]; p = m_prev[g*8+b];
          if (m_mode[g][b])     h = (s != m_pol[g][b]);
          else if (m_any[g][b]) h = (s != p);
          else if (m_pol[g][b]) h = p && !s;
          else                  h = s && !p;
          det[b] = h && m_inen[g][b];
        end
        m_pnd[g] = (m_pnd[g] & ~clr) | det;
        if (wsel) begin
          case (addr[2:0])
            3'd0: m_mode[g] = wdata;
            3'd1: m_pol[g]  = wdata;
            3'd2: m_any[g]  = wdata;
            3'd3: m_inen[g] = wdata;
            3'd4: m_ien[g]  = wdata;
            default: ;
          endcase
        end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = wake;
    end
  end

  function automatic bit [7:0] m_read(bit [4:0] a);
    int g = int'(a[4:3]);
    case (a[2:0])
      3'd0: return m_mode[g];
      3'd1: return m_pol[g];
      3'd2: return m_any[g];
      3'd3: return m_inen[g];
      3'd4: return m_ien[g];
      3'd5: return m_pnd[g];
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit [1:0] m_irq();
    bit [1:0] r = 0;
    for (int k = 0; k < NI; k++)
      for (int g = 0; g < NG; g++)
        if (MASK[k*NG+g] && ((m_pnd[g] & m_ien[g]) != 0)) r[k] = 1;
    return r;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      check(irq == m_irq(), "irq_o", irq, m_irq());
      check(rdata == m_read(addr), "reg_rdata_o", rdata, m_read(addr));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(int g, int f, bit [7:0] d);
    @(negedge clk_i);
    we = 1; addr = {g[1:0], f[2:0]}; wdata = d;
    @(negedge clk_i);
    we = 0; addr = {g[1:0], 3'd5};
  endtask

  task automatic rd(int g, int f);
    @(negedge clk_i);
    addr = {g[1:0], f[2:0]};
  endtask

  task automatic set_wake(int g, bit [7:0] v);
    @(negedge clk_i);
    wake[g*8 +: 8] = v;
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    cur_req = "watchdog";
    check(0, "timeout", 0, 1);
    report();
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    // R1 reset state
    idle(3);
    cur_req = "R1";
    check(irq == 2'b00, "irq in reset", irq, 0);
    check(rdata == 8'h00, "rdata in reset", rdata, 0);
    rst_ni = 1;
    for (int g = 0; g < NG; g++)
      for (int f = 0; f < 8; f++) rd(g, f);

    // R2 read-back of configuration fields
    cur_req = "R2";
    for (int g = 0; g < NG; g++) begin
      wr(g, 0, 8'h5A ^ g[7:0]); wr(g, 1, 8'hC3); wr(g, 2, 8'h3C);
      wr(g, 4, 8'hFF);
      for (int f = 0; f < 8; f++) rd(g, f);
      wr(g, 0, 0); wr(g, 1, 0); wr(g, 2, 0); wr(g, 4, 0);
    end

    // R11 pending field is read-only
    cur_req = "R11";
    wr(0, 5, 8'hFF); rd(0, 5);
    check(rdata == 8'h00, "pending after write", rdata, 0);

    // R3 level sensing, low-detect on upper nibble
    cur_req = "R3";
    wr(0, 0, 8'hFF); wr(0, 1, 8'hF0); wr(0, 4, 8'hFF);
    set_wake(0, 8'h0F);
    wr(0, 3, 8'hFF);
    idle(4);
    wr(0, 6, 8'hFF); rd(0, 5); idle(2);
    check(rdata == 8'hFF, "level re-set after clear", rdata, 8'hFF);
    set_wake(0, 8'hF0); idle(4);
    wr(0, 6, 8'hFF); rd(0, 5); idle(1);
    check(rdata == 8'h00, "inactive level stays clear", rdata, 0);
    wr(0, 3, 0); wr(0, 6, 8'hFF);

    // R4 edge sensing, falling on odd bits
    cur_req = "R4";
    wr(1, 1, 8'hAA); wr(1, 3, 8'hFF); wr(1, 4, 8'hFF); wr(1, 6, 8'hFF);
    set_wake(1, 8'hFF); idle(4);
    check(irq[1] == 1'b1, "rising edges", irq, 2);
    wr(1, 6, 8'hFF); idle(2);
    set_wake(1, 8'h00); idle(4);
    wr(1, 6, 8'hFF); idle(2);

    // R10 synchroniser latency: one-cycle pulse, pending on third edge
    cur_req = "R10";
    rd(1, 5);
    wake[8] = 1'b1;
    @(negedge clk_i); wake[8] = 1'b0;
    idle(1);
    check(rdata == 8'h00, "before third edge", rdata, 0);
    idle(1);
    check(rdata == 8'h01, "after third edge", rdata, 1);
    idle(2);
    wr(1, 3, 0); wr(1, 6, 8'hFF);

    // R5 any-edge overrides polarity
    cur_req = "R5";
    wr(2, 1, 8'h55); wr(2, 2, 8'hFF); wr(2, 3, 8'hFF); wr(2, 6, 8'hFF);
    set_wake(2, 8'h0F); idle(4);
    wr(2, 6, 8'hFF); idle(1);
    set_wake(2, 8'h00); rd(2, 5); idle(3);
    check(rdata == 8'h0F, "falling seen with any-edge", rdata, 8'h0F);
    wr(2, 6, 8'hFF);

    // R6 input-enable gates detection
    cur_req = "R6";
    wr(3, 4, 8'hFF);
    set_wake(3, 8'hFF); idle(4); set_wake(3, 8'h00); rd(3, 5); idle(4);
    check(rdata == 8'h00, "disabled input", rdata, 0);
    wr(3, 3, 8'hFF); wr(3, 6, 8'hFF);

    // R7 pending latched while interrupt disabled
    cur_req = "R7";
    wr(3, 4, 8'h00);
    set_wake(3, 8'h81); rd(3, 5); idle(4);
    check(rdata == 8'h81, "latched while masked", rdata, 8'h81);
    check(irq[0] == 1'b0, "masked irq", irq, 0);
    wr(3, 4, 8'h01); idle(1);

    // R8 partial clear, zero clear, clear racing a detection
    cur_req = "R8";
    wr(3, 6, 8'h00); wr(3, 6, 8'h01); rd(3, 5);
    check(rdata == 8'h80, "partial clear", rdata, 8'h80);
    wr(3, 6, 8'hFF);
    wr(0, 0, 8'h01); wr(0, 1, 8'h00);
    set_wake(0, 8'h01); wr(0, 3, 8'h01); idle(3);
    wr(0, 6, 8'h01); rd(0, 5);
    check(rdata == 8'h01, "detect wins over clear", rdata, 1);
    wr(0, 3, 0); wr(0, 6, 8'hFF);

    // R9 group merge onto shared outputs
    cur_req = "R9";
    for (int g = 0; g < NG; g++) begin
      wr(g, 0, 0); wr(g, 2, 8'hFF); wr(g, 3, 8'hFF); wr(g, 4, 8'hFF); wr(g, 6, 8'hFF);
    end
    set_wake(2, 8'hFF); idle(4);
    check(irq == 2'b10, "group 2 on irq1 only", irq, 2);
    wr(2, 6, 8'hFF); set_wake(3, 8'hFF); idle(4);
    check(irq == 2'b01, "group 3 on irq0 only", irq, 1);
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk_i);
      we = 0;
      wake[lfsr[4:0]] = ~wake[lfsr[4:0]];
      if (lfsr[9:7] == 3'd0) begin
        we = 1; addr = {lfsr[11:10], lfsr[2:0]}; wdata = lfsr[15:8];
      end else addr = {lfsr[6:5], 3'd5};
    end
    @(negedge clk_i); we = 0;
    idle(4);
    report();
  end
endmodule